// File: doc/BRIEF.md
# Dual-Pointer Indirect Address Generator

This block holds two 16-bit data pointers and works out the data-memory address for each indirect access made through them. Software loads a pointer one byte at a time. An indirect load or store then selects one of the pointers and uses it in one of two ways. In the auto-modify form, the pointer is stepped by one, up or down, before or after the access. In the offset form, a 6-bit signed literal is added to the pointer for the address, and the pointer itself is left as it was. A separate add operation moves a pointer by a signed 6-bit amount without making any access.

The register file and the ALU are outside this block. The effective address, the read and write strobes, and the loaded byte are combinational in the cycle of the operation. Pointer updates take effect at the next clock edge. For loads, the block passes on the byte returned from memory and produces the zero flag and its write enable from it. Two parameterised addresses stand for the alias registers themselves. An access that lands on either of them makes no memory access: a load returns zero and a store is dropped.

Top module: `ptr_addr_unit`

## Requirements
- R1: While rst_ni is low, both pointers read 0x0000, and mem_re_o and mem_we_o are low while no operation is requested.
- R2: A byte write with reg_we_i high loads reg_wdata_i into the pointer chosen by reg_idx_i[1], into the high byte when reg_idx_i[0] is 1 and into the low byte otherwise. The new value is visible on ptr0_o/ptr1_o after the next rising edge.
- R3: An auto-modify operation (op_i 1 = load, 2 = store) with amode_i 00 accesses pointer+1, and the pointer becomes pointer+1.
- R4: With amode_i 01, the auto-modify operation accesses pointer-1, and the pointer becomes pointer-1.
- R5: With amode_i 10, the auto-modify operation accesses the current pointer, and the pointer then becomes pointer+1.
- R6: With amode_i 11, the auto-modify operation accesses the current pointer, and the pointer then becomes pointer-1.
- R7: A store (op_i 2 or 4) uses the same mode encodings as a load, asserts mem_we_o instead of mem_re_o, and never asserts z_we_o.
- R8: An offset access (op_i 3 = load, 4 = store) uses the address pointer + sign-extended lit_i and leaves both pointers unchanged.
- R9: The add operation (op_i 5) adds the sign-extended lit_i (range -32..+31) to the selected pointer and asserts neither mem_re_o nor mem_we_o.
- R10: Pointer and address arithmetic is modulo 2^16, and a carry or borrow crosses from the low byte into the high byte.
- R11: On a load, z_we_o is high and z_o is 1 exactly when load_data_o is 0x00. When no load is made, z_we_o is low.
- R12: When a byte write targets the same pointer as an auto-modify or add in the same cycle, only the written byte changes and the arithmetic update of that pointer is dropped.
- R13: An access whose effective address equals ALIAS0_ADDR or ALIAS1_ADDR asserts neither strobe, and a load returns 0x00 (so z_o = 1). Any auto-modify of the pointer still takes place.
- R14: An operation on one pointer never changes the other pointer, except through a byte write addressed to that other pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | 0 idle, 1 auto load, 2 auto store, 3 offset load, 4 offset store, 5 add to pointer |
| sel_i | input | 1 | Pointer index for op_i |
| amode_i | input | 2 | Auto-modify mode: 00 pre-inc, 01 pre-dec, 10 post-inc, 11 post-dec |
| lit_i | input | 6 | Signed literal for offset and add |
| reg_we_i | input | 1 | Pointer byte write enable |
| reg_idx_i | input | 2 | [1] pointer, [0] high byte |
| reg_wdata_i | input | 8 | Pointer byte write data |
| rd_data_i | input | 8 | Byte returned from data memory |
| mem_addr_o | output | 16 | Effective data address |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| load_data_o | output | 8 | Byte delivered to W on a load |
| z_o | output | 1 | Zero flag value for a load |
| z_we_o | output | 1 | Zero flag update enable |
| ptr0_o | output | 16 | Pointer 0 |
| ptr1_o | output | 16 | Pointer 1 |

## Verification
The bench steps a pointer from 0x12FF so that the low byte carries into the high byte. A design that increments only the low byte would show 0x1200 instead of 0x1300. It decrements and post-decrements across 0x0000 and 0xFFFF, and lands accesses on the alias addresses. A design that leaked these through would raise a strobe or return memory data instead of zero. It also collides a byte write with an auto-modify on the same pointer and on the other pointer. If the priority were wrong, the arithmetic result would overwrite the written byte, or a valid update of the other pointer would be lost. Offset and add literals of -32 and +31 catch a literal that is zero-extended instead of sign-extended.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_LD_AUTO = 3'd1,
    OP_ST_AUTO = 3'd2,
    OP_LD_OFS  = 3'd3,
    OP_ST_OFS  = 3'd4,
    OP_ADD     = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    AM_PRE_INC  = 2'b00,
    AM_PRE_DEC  = 2'b01,
    AM_POST_INC = 2'b10,
    AM_POST_DEC = 2'b11
  } amode_e;
endpackage

// File: rtl/ptr_agu.sv
module ptr_agu
  import ptr_pkg::*;
#(
  parameter int PW = 16,
  parameter int LW = 6
) (
  input  logic [PW-1:0] ptr_i,
  input  op_e           op_i,
  input  amode_e        amode_i,
  input  logic [LW-1:0] lit_i,
  output logic [PW-1:0] ea_o,
  output logic [PW-1:0] nxt_o,
  output logic          upd_o,
  output logic          acc_o,
  output logic          st_o
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] ofs, inc, dec;

  assign ofs = {{(PW-LW){lit_i[LW-1]}}, lit_i};
  assign inc = ptr_i + ONE;
  assign dec = ptr_i - ONE;

  always_comb begin
    ea_o  = ptr_i;
    nxt_o = ptr_i;
    upd_o = 1'b0;
    acc_o = 1'b0;
    st_o  = 1'b0;
    unique case (op_i)
      OP_LD_AUTO, OP_ST_AUTO: begin
        acc_o = 1'b1;
        st_o  = (op_i == OP_ST_AUTO);
        upd_o = 1'b1;
        unique case (amode_i)
          AM_PRE_INC:  begin ea_o = inc; nxt_o = inc; end
          AM_PRE_DEC:  begin ea_o = dec; nxt_o = dec; end
          AM_POST_INC: nxt_o = inc;
          AM_POST_DEC: nxt_o = dec;
          default:     nxt_o = ptr_i;
        endcase
      end
      OP_LD_OFS, OP_ST_OFS: begin
        acc_o = 1'b1;
        st_o  = (op_i == OP_ST_OFS);
        ea_o  = ptr_i + ofs;
      end
      OP_ADD: begin
        nxt_o = ptr_i + ofs;
        upd_o = 1'b1;
      end
      default: upd_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptr_reg.sv
module ptr_reg #(
  parameter int PW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic [PW-1:0]   nxt_i,
  input  logic            bw_lo_i,
  input  logic            bw_hi_i,
  input  logic [PW/2-1:0] bdata_i,
  output logic [PW-1:0]   ptr_o
);
  localparam int BW = PW / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
    end else if (bw_lo_i || bw_hi_i) begin
      // explicit byte write beats arithmetic update
      if (bw_lo_i) ptr_o[BW-1:0]  <= bdata_i;
      if (bw_hi_i) ptr_o[PW-1:BW] <= bdata_i;
    end else if (upd_i) begin
      ptr_o <= nxt_i;
    end
  end
endmodule

// File: rtl/alias_guard.sv
module alias_guard #(
  parameter int            PW     = 16,
  parameter logic [PW-1:0] ALIAS0 = '0,
  parameter logic [PW-1:0] ALIAS1 = '0
) (
  input  logic [PW-1:0] ea_i,
  input  logic          acc_i,
  input  logic          st_i,
  input  logic [7:0]    rd_data_i,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [7:0]    load_data_o,
  output logic          z_o,
  output logic          z_we_o
);
  logic hit;

  assign hit         = acc_i && ((ea_i == ALIAS0) || (ea_i == ALIAS1));
  assign mem_re_o    = acc_i && !st_i && !hit;
  assign mem_we_o    = acc_i && st_i && !hit;
  assign load_data_o = hit ? 8'h00 : rd_data_i;
  assign z_o         = (load_data_o == 8'h00);
  assign z_we_o      = acc_i && !st_i;
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
  import ptr_pkg::*;
#(
  parameter int            PW          = 16,
  parameter int            LW          = 6,
  parameter logic [PW-1:0] ALIAS0_ADDR = 16'h0000,
  parameter logic [PW-1:0] ALIAS1_ADDR = 16'h0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic          sel_i,
  input  logic [1:0]    amode_i,
  input  logic [LW-1:0] lit_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_idx_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic [7:0]    rd_data_i,
  output logic [PW-1:0] mem_addr_o,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [7:0]    load_data_o,
  output logic          z_o,
  output logic          z_we_o,
  output logic [PW-1:0] ptr0_o,
  output logic [PW-1:0] ptr1_o
);
  localparam int NPTR = 2;
  localparam int BW   = PW / 2;

  logic [PW-1:0] ptr_q [NPTR];
  logic [PW-1:0] ptr_sel, ea, nxt;
  logic          upd, acc, st;

  assign ptr_sel = ptr_q[sel_i];

  ptr_agu #(.PW(PW), .LW(LW)) u_agu (
    .ptr_i   (ptr_sel),
    .op_i    (op_e'(op_i)),
    .amode_i (amode_e'(amode_i)),
    .lit_i   (lit_i),
    .ea_o    (ea),
    .nxt_o   (nxt),
    .upd_o   (upd),
    .acc_o   (acc),
    .st_o    (st)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic wr_this;
    assign wr_this = reg_we_i && (int'(reg_idx_i[1]) == g);
    ptr_reg #(.PW(PW)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .upd_i   (upd && (int'(sel_i) == g)),
      .nxt_i   (nxt),
      .bw_lo_i (wr_this && !reg_idx_i[0]),
      .bw_hi_i (wr_this && reg_idx_i[0]),
      .bdata_i (reg_wdata_i[BW-1:0]),
      .ptr_o   (ptr_q[g])
    );
  end

  alias_guard #(.PW(PW), .ALIAS0(ALIAS0_ADDR), .ALIAS1(ALIAS1_ADDR)) u_guard (
    .ea_i        (ea),
    .acc_i       (acc),
    .st_i        (st),
    .rd_data_i   (rd_data_i),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .load_data_o (load_data_o),
    .z_o         (z_o),
    .z_we_o      (z_we_o)
  );

  assign mem_addr_o = ea;
  assign ptr0_o     = ptr_q[0];
  assign ptr1_o     = ptr_q[1];
endmodule

// File: rtl/ptr_addr_unit_chk.sv
module ptr_addr_unit_chk #(
  parameter int            PW          = 16,
  parameter logic [PW-1:0] ALIAS0_ADDR = 16'h0000,
  parameter logic [PW-1:0] ALIAS1_ADDR = 16'h0001
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    op_i,
  input logic          sel_i,
  input logic [1:0]    amode_i,
  input logic          reg_we_i,
  input logic [1:0]    reg_idx_i,
  input logic [PW-1:0] mem_addr_o,
  input logic          mem_re_o,
  input logic          mem_we_o,
  input logic          z_we_o,
  input logic [PW-1:0] ptr0_o,
  input logic [PW-1:0] ptr1_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_zero_r1: assert (ptr0_o == '0 && ptr1_o == '0);
    end
  end

  p_post_inc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && amode_i == 2'b10 && !sel_i && !reg_we_i)
      |=> ptr0_o == $past(ptr0_o) + PW'(1));

  p_ofs_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == 3'd3 || op_i == 3'd4) && !reg_we_i) |=> ($stable(ptr0_o) && $stable(ptr1_o)));

  p_store_no_z_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 || op_i == 3'd4) |-> (!z_we_o && !mem_re_o));

  p_add_no_acc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5) |-> (!mem_re_o && !mem_we_o));

  p_alias_block_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_addr_o == ALIAS0_ADDR || mem_addr_o == ALIAS1_ADDR) |-> (!mem_re_o && !mem_we_o));

  p_other_hold_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !(reg_we_i && reg_idx_i[1])) |=> $stable(ptr1_o));

  p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
endmodule

bind ptr_addr_unit ptr_addr_unit_chk #(
  .PW(PW), .ALIAS0_ADDR(ALIAS0_ADDR), .ALIAS1_ADDR(ALIAS1_ADDR)
) u_chk (.*);

// File: tb/ptr_addr_unit_bench.sv
module ptr_addr_unit_bench;
  localparam logic [15:0] A0 = 16'h0000;
  localparam logic [15:0] A1 = 16'h0001;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [2:0]  op_i;
  logic        sel_i;
  logic [1:0]  amode_i;
  logic [5:0]  lit_i;
  logic        reg_we_i;
  logic [1:0]  reg_idx_i;
  logic [7:0]  reg_wdata_i;
  logic [7:0]  rd_data_i;
  logic [15:0] mem_addr_o;
  logic        mem_re_o, mem_we_o;
  logic [7:0]  load_data_o;
  logic        z_o, z_we_o;
  logic [15:0] ptr0_o, ptr1_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] mp [2];

  always #5 clk_i = ~clk_i;

  ptr_addr_unit #(.ALIAS0_ADDR(A0), .ALIAS1_ADDR(A1)) u_ptr_addr_unit (.*);

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, int op, int sel, int am, logic [5:0] lit,
                      bit we, int idx, logic [7:0] wd, logic [7:0] rd);
    logic [15:0] p, ofs, ea, nx;
    bit acc, st, hit, upd;
    logic [7:0] ld;
    op_i = 3'(op); sel_i = sel[0]; amode_i = 2'(am); lit_i = lit;
    reg_we_i = we; reg_idx_i = 2'(idx); reg_wdata_i = wd; rd_data_i = rd;
    #2;
    p   = mp[sel];
    ofs = {{10{lit[5]}}, lit};
    acc = (op >= 1 && op <= 4);
    st  = (op == 2 || op == 4);
    ea = p; nx = p; upd = 0;
    if (op == 1 || op == 2) begin
      upd = 1;
      case (am)
        0: begin ea = p + 16'd1; nx = p + 16'd1; end
        1: begin ea = p - 16'd1; nx = p - 16'd1; end
        2: nx = p + 16'd1;
        default: nx = p - 16'd1;
      endcase
    end else if (op == 3 || op == 4) begin
      ea = p + ofs;
    end else if (op == 5) begin
      nx = p + ofs; upd = 1;
    end
    hit = acc && (ea == A0 || ea == A1);
    chk(tag, "ptr0", ptr0_o, mp[0]);
    chk(tag, "ptr1", ptr1_o, mp[1]);
    chk(tag, "mem_re", 16'(mem_re_o), 16'(acc && !st && !hit));
    chk(tag, "mem_we", 16'(mem_we_o), 16'(st && !hit));
    chk(tag, "z_we", 16'(z_we_o), 16'(acc && !st));
    if (acc) chk(tag, "addr", mem_addr_o, ea);
    if (acc && !st) begin
      ld = hit ? 8'h00 : rd;
      chk(tag, "load_data", 16'(load_data_o), 16'(ld));
      chk(tag, "z", 16'(z_o), 16'(ld == 8'h00));
    end
    @(posedge clk_i);
    for (int k = 0; k < 2; k++) begin
      if (we && (idx / 2) == k) begin
        if (idx % 2 == 1) mp[k][15:8] = wd;
        else              mp[k][7:0]  = wd;
      end else if (upd && sel == k) begin
        mp[k] = nx;
      end
    end
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    mp[0] = '0; mp[1] = '0;
    rst_ni = 1'b0;
    op_i = '0; sel_i = 0; amode_i = '0; lit_i = '0;
    reg_we_i = 0; reg_idx_i = '0; reg_wdata_i = '0; rd_data_i = '0;
    @(negedge clk_i); @(negedge clk_i);
    chk("R1", "ptr0 in reset", ptr0_o, 16'h0000);
    chk("R1", "ptr1 in reset", ptr1_o, 16'h0000);
    chk("R1", "strobes idle", 16'({mem_re_o, mem_we_o}), 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step("R1", 0, 0, 0, 6'h00, 0, 0, 8'h00, 8'h00);

    // R2 byte loads
    step("R2", 0, 0, 0, 6'h00, 1, 0, 8'hFF, 8'h00);
    step("R2", 0, 0, 0, 6'h00, 1, 1, 8'h12, 8'h00);
    step("R2", 0, 0, 0, 6'h00, 1, 3, 8'h80, 8'h00);
    step("R2", 0, 0, 0, 6'h00, 0, 0, 8'h00, 8'h00);

    // R3/R10 carry from 0x12FF into high byte
    step("R3", 1, 0, 0, 6'h00, 0, 0, 8'h00, 8'h00);
    step("R4", 1, 0, 1, 6'h00, 0, 0, 8'h00, 8'h3C);
    step("R5", 1, 0, 2, 6'h00, 0, 0, 8'h00, 8'h11);
    step("R7", 2, 1, 2, 6'h00, 0, 0, 8'h00, 8'h00);
    step("R6", 1, 1, 3, 6'h00, 0, 0, 8'h00, 8'h44);
    step("R7", 2, 0, 0, 6'h00, 0, 0, 8'h00, 8'h00);
    step("R7", 2, 1, 1, 6'h00, 0, 0, 8'h00, 8'h00);

    // R8 offset extremes
    step("R8", 3, 0, 0, 6'h20, 0, 0, 8'h00, 8'h9A);
    step("R8", 4, 1, 0, 6'h1F, 0, 0, 8'h00, 8'h00);
    step("R8", 0, 0, 0, 6'h00, 0, 0, 8'h00, 8'h00);

    // R9 add to pointer
    step("R9", 5, 1, 0, 6'h3F, 0, 0, 8'h00, 8'h00);
    step("R9", 5, 0, 0, 6'h1F, 0, 0, 8'h00, 8'h00);
    step("R9", 5, 0, 0, 6'h20, 0, 0, 8'h00, 8'h00);

    // R10/R13 wrap onto alias addresses
    step("R10", 0, 0, 0, 6'h00, 1, 2, 8'hFF, 8'h00);
    step("R10", 0, 0, 0, 6'h00, 1, 3, 8'hFF, 8'h00);
    step("R13", 1, 1, 0, 6'h00, 0, 0, 8'h00, 8'h5A);
    step("R13", 2, 1, 3, 6'h00, 0, 0, 8'h00, 8'h00);
    step("R10", 5, 1, 0, 6'h02, 0, 0, 8'h00, 8'h00);
    step("R13", 4, 1, 0, 6'h00, 0, 0, 8'h00, 8'h00);
    step("R13", 3, 1, 0, 6'h3F, 0, 0, 8'h00, 8'h77);

    // R11 zero flag
    step("R11", 1, 0, 2, 6'h00, 0, 0, 8'h00, 8'h00);
    step("R11", 1, 0, 2, 6'h00, 0, 0, 8'h00, 8'h80);

    // R12 write beats auto-modify on same pointer
    step("R12", 1, 0, 2, 6'h00, 1, 0, 8'h77, 8'h01);
    step("R12", 5, 0, 0, 6'h1F, 1, 1, 8'h3C, 8'h00);
    step("R12", 0, 0, 0, 6'h00, 0, 0, 8'h00, 8'h00);

    // R14 write to other pointer alongside auto-modify
    step("R14", 2, 0, 1, 6'h00, 1, 2, 8'hA5, 8'h00);
    step("R14", 1, 1, 3, 6'h00, 0, 0, 8'h00, 8'h22);
    step("R14", 0, 0, 0, 6'h00, 0, 0, 8'h00, 8'h00);

    for (int i = 0; i < 400; i++) begin
      step("RND", int'($urandom_range(0, 5)), int'($urandom_range(0, 1)),
           int'($urandom_range(0, 3)), 6'($urandom), ($urandom_range(0, 3) == 0),
           int'($urandom_range(0, 3)), 8'($urandom), 8'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule